// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block moves the bytes of a configuration item between an item store and system memory, under the control of a 16-byte descriptor that sits in memory. The host writes the 64-bit physical address of a descriptor into the engine's address register, and that write starts the transfer. The engine fetches the descriptor and, if asked, changes the selected item. It then reads, writes or skips the requested number of bytes. At the end it writes a control word back into the descriptor to report success or failure. The selected item key and the byte offset inside it are shared with a separate selector port. The offset left behind by one transfer is where the next transfer, or the next selector access, continues. When the host reads the address register it gets bytes of a fixed 64-bit signature, so software can tell that the engine is present.

The descriptor is stored big-endian: bytes 0..3 hold the control word, bytes 4..7 the length and bytes 8..15 the memory address. Control bits: bit 0 error, bit 1 read (item to memory), bit 2 skip, bit 3 select, bit 4 write (memory to item). When select is set, bits 31:16 carry the new item key. The memory side is a byte-wide request/acknowledge master: a request is held until it is acknowledged, and an error flag arrives together with the acknowledge. The item store answers combinationally for the current key and offset, giving the item's validity, writability, length and the data byte at the current offset.

The controller runs as one state machine. ST_IDLE goes to ST_FETCH on an accepted trigger. ST_FETCH reads 16 descriptor bytes and then goes to ST_DECODE, or to ST_WBACK on a fault. ST_DECODE applies the optional select and goes to ST_STEP when an operation is requested, or to ST_WBACK when none is. ST_STEP goes to ST_WBACK when the length is used up, on an error, or after a skip. Otherwise it goes to ST_PUT to store one byte to memory (read operation) or to ST_GET to load one byte from memory (write operation). ST_PUT and ST_GET return to ST_STEP on acknowledge, or go to ST_WBACK on a fault. ST_WBACK stores the 4 control-word bytes and returns to ST_IDLE.

Top module: `cfg_dma_engine`

## Requirements
- R1: A register write is accepted only when it is 4 bytes at offset 0 or 4, or 8 bytes at offset 0. Any other write raises reg_rej in the same cycle and starts nothing.
- R2: reg_rdata returns the `reg_size` bytes of the 64-bit signature (default 0x4346_4744_4D41_3031), starting `reg_off` bytes from its most significant byte. The bytes are right-aligned and the upper bits are zero. A combination that runs past byte 8 returns zero.
- R3: A transfer starts on an 8-byte write at offset 0 (address = reg_wdata), or on a 4-byte write at offset 4 (address = held high half OR reg_wdata[31:0]). A 4-byte write at offset 0 holds reg_wdata[31:0] as the high half. The held high half is cleared whenever a transfer starts.
- R4: The descriptor is fetched big-endian from its address: control word at +0, length at +4, memory address at +8. When control bit 3 is set, bits 31:16 become the selected key and the offset is reset to 0.
- R5: The operation is read when bit 1 is set, else write when bit 4 is set, else skip when bit 2 is set. With none of these bits set, only the optional select is performed and the transfer completes.
- R6: A read copies item bytes from the current offset to consecutive memory addresses. Once the item is exhausted or the key is invalid, the rest of the length is filled with zero bytes. The offset advances only over bytes that were really copied.
- R7: A write copies memory bytes into the item at the current offset. A read-only item, an invalid key, or reaching the end of the item sets the error and stops the transfer. Bytes copied before that point stay copied.
- R8: A skip advances the offset by the smaller of the length and the remaining item bytes (by nothing for an invalid item), and then completes.
- R9: A memory fault during a data byte sets the error and ends the transfer. A fault during the descriptor fetch skips all data movement and reports error.
- R10: The control word at descriptor bytes 0..3 is rewritten big-endian: 0x00000000 on success, 0x00000001 on error. No other descriptor byte is written.
- R11: busy is high from the cycle after an accepted trigger until the write-back completes. While busy, register writes and selector-port writes are ignored. A memory request holds its address and direction until it is acknowledged.
- R12: After reset the engine is idle, the selected key is 0 and the offset is 0.
- R13: A selector-port write while idle selects sel_key with offset 0. The offset left by one transfer carries over into the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Address register write strobe |
| reg_off | input | 3 | Byte offset of the register access |
| reg_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Signature read data for reg_off/reg_size |
| reg_rej | output | 1 | Current write has an illegal size or offset |
| sel_wr | input | 1 | Selector-port key write |
| sel_key | input | 16 | Key written by the selector port |
| busy | output | 1 | Transfer in progress |
| cur_key | output | 16 | Currently selected item key |
| cur_off | output | 32 | Current byte offset in the item |
| item_valid | input | 1 | Current key names an existing item |
| item_writable | input | 1 | Current item accepts writes |
| item_len | input | 32 | Length of the current item in bytes |
| item_rdata | input | 8 | Item byte at cur_off |
| item_wr | output | 1 | Store item_wdata at cur_off of the current item |
| item_wdata | output | 8 | Byte to store into the item |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a byte store |
| mem_addr | output | 64 | Byte address of the request |
| mem_wdata | output | 8 | Store data |
| mem_ack | input | 1 | Request completes this cycle |
| mem_err | input | 1 | Completing request faulted |
| mem_rdata | input | 8 | Load data, valid with mem_ack |

## Verification
On every cycle, the assertions check several port-level properties. Illegal write sizes must be rejected and a 64-bit trigger must raise busy. Narrow signature reads must keep their upper bits clear. Memory requests must be stable until they are acknowledged and must occur only while busy. Item stores must go only to writable items. A selector-port write while idle must select the key at offset zero. Only the bench scenarios can show the data-path results: the big-endian descriptor layout, the read/write/skip priority, zero-fill past the end of an item, the offset carried between transfers, the stop on a read-only or exhausted item, fetch and data faults, and the write-back values. They also show the held address half being cleared, and triggers and selects being ignored while busy.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

    localparam int ADDR_W     = 64;
    localparam int KEY_W      = 16;
    localparam int LEN_W      = 32;
    localparam int DESC_BYTES = 16;
    localparam int DESC_W     = DESC_BYTES * 8;
    localparam int CNT_W      = $clog2(DESC_BYTES);
    localparam int CTL_BYTES  = 4;

    // control word bit positions (software visible)
    localparam int CB_ERR  = 0;
    localparam int CB_RD   = 1;
    localparam int CB_SKIP = 2;
    localparam int CB_SEL  = 3;
    localparam int CB_WR   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_STEP,
        ST_PUT,
        ST_GET,
        ST_WBACK
    } eng_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_SKIP
    } eng_op_t;

    function automatic logic [63:0] sig_slice(input logic [63:0] sig,
                                              input logic [2:0]  off,
                                              input logic [3:0]  size);
        logic [63:0] val;
        int          span;
        span = int'(off) + int'(size);
        if (!(size == 4'd1 || size == 4'd2 || size == 4'd4 || size == 4'd8) || span > 8)
            return 64'd0;
        val = sig >> (8 * (8 - span));
        if (size != 4'd8)
            val = val & ((64'd1 << (8 * int'(size))) - 64'd1);
        return val;
    endfunction

endpackage

// File: rtl/cfg_dma_regif.sv
module cfg_dma_regif
    import cfg_dma_pkg::*;
#(
    parameter logic [63:0] SIGNATURE = 64'h4346_4744_4D41_3031
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr,
    input  logic [2:0]        off,
    input  logic [3:0]        size,
    input  logic [63:0]       wdata,
    output logic [63:0]       rdata,
    output logic              rej,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr
);

    logic              legal;
    logic              take;
    logic [ADDR_W-1:0] hi_q;

    assign legal = (size == 4'd4 && (off == 3'd0 || off == 3'd4)) ||
                   (size == 4'd8 && off == 3'd0);
    assign rej   = wr && !legal;
    assign take  = wr && legal && !busy;
    assign start = take && (size == 4'd8 || off == 3'd4);
    assign rdata = sig_slice(SIGNATURE, off, size);

    always_comb begin
        if (size == 4'd8)
            start_addr = wdata[ADDR_W-1:0];
        else
            start_addr = hi_q | {32'd0, wdata[31:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_q <= '0;
        else if (start)
            hi_q <= '0;
        else if (take)
            hi_q <= {wdata[31:0], 32'd0};
    end

endmodule

// File: rtl/cfg_dma_sel.sv
module cfg_dma_sel
    import cfg_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             port_wr,
    input  logic [KEY_W-1:0] port_key,
    input  logic             dma_sel,
    input  logic [KEY_W-1:0] dma_key,
    input  logic             adv,
    input  logic [LEN_W-1:0] adv_n,
    output logic [KEY_W-1:0] cur_key,
    output logic [LEN_W-1:0] cur_off
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_key <= '0;
            cur_off <= '0;
        end else if (dma_sel) begin
            cur_key <= dma_key;
            cur_off <= '0;
        end else if (port_wr && !busy) begin
            cur_key <= port_key;
            cur_off <= '0;
        end else if (adv) begin
            cur_off <= cur_off + adv_n;
        end
    end

endmodule

// File: rtl/cfg_dma_fsm.sv
module cfg_dma_fsm
    import cfg_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata,
    input  logic              item_valid,
    input  logic              item_writable,
    input  logic [LEN_W-1:0]  item_len,
    input  logic [7:0]        item_rdata,
    input  logic [LEN_W-1:0]  cur_off,
    output logic              item_wr,
    output logic [7:0]        item_wdata,
    output logic              dma_sel,
    output logic [KEY_W-1:0]  dma_key,
    output logic              adv,
    output logic [LEN_W-1:0]  adv_n
);

    eng_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DESC_W-1:0] desc_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] maddr_q;
    logic [LEN_W-1:0]  len_q;
    eng_op_t           op_q;
    logic              err_q;
    logic [7:0]        byte_q;
    logic              from_item_q;

    logic [31:0]       ctl_w;
    eng_op_t           op_dec;
    logic              avail;
    logic [LEN_W-1:0]  rem;
    logic [LEN_W-1:0]  skip_n;
    logic              ok_ack;

    assign ctl_w  = desc_q[DESC_W-1 -: 32];
    assign avail  = item_valid && (cur_off < item_len);
    assign rem    = item_len - cur_off;
    assign skip_n = (len_q < rem) ? len_q : rem;
    assign ok_ack = mem_ack && !mem_err;

    always_comb begin
        if (ctl_w[CB_RD])
            op_dec = OP_READ;
        else if (ctl_w[CB_WR])
            op_dec = OP_WRITE;
        else if (ctl_w[CB_SKIP])
            op_dec = OP_SKIP;
        else
            op_dec = OP_NONE;
    end

    // state register and transfer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            desc_q      <= '0;
            base_q      <= '0;
            maddr_q     <= '0;
            len_q       <= '0;
            op_q        <= OP_NONE;
            err_q       <= 1'b0;
            byte_q      <= '0;
            from_item_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q  <= start_addr;
                        cnt_q   <= '0;
                        err_q   <= 1'b0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            err_q   <= 1'b1;
                            cnt_q   <= '0;
                            state_q <= ST_WBACK;
                        end else begin
                            desc_q <= {desc_q[DESC_W-9:0], mem_rdata};
                            cnt_q  <= cnt_q + 1'b1;
                            if (cnt_q == CNT_W'(DESC_BYTES - 1))
                                state_q <= ST_DECODE;
                        end
                    end
                end
                ST_DECODE: begin
                    len_q   <= desc_q[DESC_W-33 -: LEN_W];
                    maddr_q <= desc_q[ADDR_W-1:0];
                    op_q    <= op_dec;
                    cnt_q   <= '0;
                    state_q <= (op_dec == OP_NONE) ? ST_WBACK : ST_STEP;
                end
                ST_STEP: begin
                    if (len_q == '0) begin
                        state_q <= ST_WBACK;
                    end else begin
                        unique case (op_q)
                            OP_READ: begin
                                byte_q      <= avail ? item_rdata : 8'd0;
                                from_item_q <= avail;
                                state_q     <= ST_PUT;
                            end
                            OP_WRITE: begin
                                if (!avail || !item_writable) begin
                                    err_q   <= 1'b1;
                                    state_q <= ST_WBACK;
                                end else begin
                                    state_q <= ST_GET;
                                end
                            end
                            OP_SKIP: begin
                                len_q   <= '0;
                                maddr_q <= maddr_q + ADDR_W'(len_q);
                                state_q <= ST_WBACK;
                            end
                            default: state_q <= ST_WBACK;
                        endcase
                    end
                end
                ST_PUT, ST_GET: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            err_q   <= 1'b1;
                            state_q <= ST_WBACK;
                        end else begin
                            maddr_q <= maddr_q + 1'b1;
                            len_q   <= len_q - 1'b1;
                            state_q <= ST_STEP;
                        end
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(CTL_BYTES - 1))
                            state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        item_wr    = 1'b0;
        item_wdata = mem_rdata;
        dma_sel    = 1'b0;
        dma_key    = ctl_w[31:16];
        adv        = 1'b0;
        adv_n      = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = base_q + ADDR_W'(cnt_q);
            end
            ST_DECODE: begin
                dma_sel = ctl_w[CB_SEL];
            end
            ST_STEP: begin
                if (op_q == OP_SKIP && len_q != '0 && avail) begin
                    adv   = 1'b1;
                    adv_n = skip_n;
                end
            end
            ST_PUT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = maddr_q;
                mem_wdata = byte_q;
                if (ok_ack && from_item_q) begin
                    adv   = 1'b1;
                    adv_n = LEN_W'(1);
                end
            end
            ST_GET: begin
                mem_req  = 1'b1;
                mem_addr = maddr_q;
                if (ok_ack) begin
                    item_wr = 1'b1;
                    adv     = 1'b1;
                    adv_n   = LEN_W'(1);
                end
            end
            ST_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = base_q + ADDR_W'(cnt_q);
                // big-endian control word: only the last byte carries the error bit
                mem_wdata = (cnt_q == CNT_W'(CTL_BYTES - 1)) ? {7'd0, err_q} : 8'd0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
    import cfg_dma_pkg::*;
#(
    parameter logic [63:0] SIGNATURE = 64'h4346_4744_4D41_3031
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_off,
    input  logic [3:0]  reg_size,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        reg_rej,
    input  logic        sel_wr,
    input  logic [15:0] sel_key,
    output logic        busy,
    output logic [15:0] cur_key,
    output logic [31:0] cur_off,
    input  logic        item_valid,
    input  logic        item_writable,
    input  logic [31:0] item_len,
    input  logic [7:0]  item_rdata,
    output logic        item_wr,
    output logic [7:0]  item_wdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [63:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [7:0]  mem_rdata
);

    logic              start;
    logic [ADDR_W-1:0] start_addr;
    logic              dma_sel;
    logic [KEY_W-1:0]  dma_key;
    logic              adv;
    logic [LEN_W-1:0]  adv_n;

    cfg_dma_regif #(.SIGNATURE(SIGNATURE)) regif_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .wr         (reg_wr),
        .off        (reg_off),
        .size       (reg_size),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .rej        (reg_rej),
        .start      (start),
        .start_addr (start_addr)
    );

    cfg_dma_sel sel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .port_wr  (sel_wr),
        .port_key (sel_key),
        .dma_sel  (dma_sel),
        .dma_key  (dma_key),
        .adv      (adv),
        .adv_n    (adv_n),
        .cur_key  (cur_key),
        .cur_off  (cur_off)
    );

    cfg_dma_fsm fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .start_addr    (start_addr),
        .busy          (busy),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ack       (mem_ack),
        .mem_err       (mem_err),
        .mem_rdata     (mem_rdata),
        .item_valid    (item_valid),
        .item_writable (item_writable),
        .item_len      (item_len),
        .item_rdata    (item_rdata),
        .cur_off       (cur_off),
        .item_wr       (item_wr),
        .item_wdata    (item_wdata),
        .dma_sel       (dma_sel),
        .dma_key       (dma_key),
        .adv           (adv),
        .adv_n         (adv_n)
    );

endmodule

// File: rtl/cfg_dma_chk.sv
module cfg_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_off,
    input logic [3:0]  reg_size,
    input logic [63:0] reg_rdata,
    input logic        reg_rej,
    input logic        sel_wr,
    input logic [15:0] sel_key,
    input logic        busy,
    input logic [15:0] cur_key,
    input logic [31:0] cur_off,
    input logic        item_writable,
    input logic        item_wr,
    input logic        mem_req,
    input logic        mem_we,
    input logic [63:0] mem_addr,
    input logic        mem_ack
);

    // R1: sizes other than 4 or 8 bytes are never legal writes
    p_bad_size_rej_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_size != 4'd4 && reg_size != 4'd8 |-> reg_rej);

    // R2: a 4-byte signature read carries nothing above bit 31
    p_narrow_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_size == 4'd4 |-> reg_rdata[63:32] == 32'd0);

    // R3: a full-width trigger while idle starts a transfer
    p_trigger_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && reg_wr && reg_size == 4'd8 && reg_off == 3'd0 |=> busy);

    // R11: an outstanding request stays put until acknowledged
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R11: memory is only touched during a transfer
    p_req_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R7: item stores only reach writable items
    p_item_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        item_wr |-> item_writable && busy);

    // R13: idle selector write picks the key at offset zero
    p_port_select_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && sel_wr |=> cur_off == 32'd0 && cur_key == $past(sel_key));

endmodule

bind cfg_dma_engine cfg_dma_chk chk_i (.*);

// File: tb/cfg_dma_engine_tb.sv
module cfg_dma_engine_tb_top;

    localparam logic [31:0] C_RD   = 32'h02;
    localparam logic [31:0] C_SKIP = 32'h04;
    localparam logic [31:0] C_SEL  = 32'h08;
    localparam logic [31:0] C_WR   = 32'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_off = 3'd0;
    logic [3:0]  reg_size = 4'd8;
    logic [63:0] reg_wdata = 64'd0;
    logic [63:0] reg_rdata;
    logic        reg_rej;
    logic        sel_wr = 1'b0;
    logic [15:0] sel_key = 16'd0;
    logic        busy;
    logic [15:0] cur_key;
    logic [31:0] cur_off;
    logic        item_valid, item_writable;
    logic [31:0] item_len;
    logic [7:0]  item_rdata;
    logic        item_wr;
    logic [7:0]  item_wdata;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack;
    logic        mem_err;
    logic [7:0]  mem_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    cfg_dma_engine dut_i (.*);

    // ---------------- memory model (reads at 0xE0..0xFF fault) ----------------
    logic [7:0] mem [0:255];
    wire fault_wr = (mem_addr[63:8] != 56'd0);
    wire fault_rd = fault_wr || (!mem_we && mem_addr[7:0] >= 8'hE0);
    assign mem_rdata = fault_rd ? 8'd0 : mem[mem_addr[7:0]];
    assign mem_err   = mem_ack && (mem_we ? fault_wr : fault_rd);

    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else        mem_ack <= mem_req && !mem_ack;
        if (rst_n && mem_req && mem_ack && mem_we && !fault_wr)
            mem[mem_addr[7:0]] <= mem_wdata;
    end

    // ---------------- item store model: key0 len4 RO, key1 len6 RW, key2 len2 RO ----
    logic [7:0] itm [0:2][0:7];
    function automatic logic [31:0] len_of(input logic [15:0] k);
        case (k)
            16'd0:   return 32'd4;
            16'd1:   return 32'd6;
            16'd2:   return 32'd2;
            default: return 32'd0;
        endcase
    endfunction
    assign item_valid    = (cur_key < 16'd3);
    assign item_writable = (cur_key == 16'd1);
    assign item_len      = len_of(cur_key);
    assign item_rdata    = (item_valid && cur_off < 32'd8) ? itm[cur_key[1:0]][cur_off[2:0]] : 8'd0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                itm[0][i] <= 8'd0; itm[1][i] <= 8'd0; itm[2][i] <= 8'd0;
            end
            itm[0][0] <= 8'h53; itm[0][1] <= 8'h49; itm[0][2] <= 8'h47; itm[0][3] <= 8'h4E;
            for (int i = 0; i < 6; i++) itm[1][i] <= 8'h10 + 8'(i);
            itm[2][0] <= 8'h77; itm[2][1] <= 8'h78;
        end else if (item_wr && cur_key < 16'd3 && cur_off < 32'd8) begin
            itm[cur_key[1:0]][cur_off[2:0]] <= item_wdata;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_desc(input logic [7:0] a, input logic [31:0] ctl,
                            input logic [31:0] len, input logic [63:0] addr);
        logic [127:0] d;
        d = {ctl, len, addr};
        for (int i = 0; i < 16; i++) mem[a + 8'(i)] = d[127 - 8*i -: 8];
    endtask

    function automatic logic [31:0] word_at(input logic [7:0] a);
        return {mem[a], mem[a + 8'd1], mem[a + 8'd2], mem[a + 8'd3]};
    endfunction

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] off, input logic [3:0] size, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_off = off; reg_size = size; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run64(input logic [63:0] a);
        wr_reg(3'd0, 4'd8, a);
        wait_idle();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R12 busy after reset", busy, 0);
        check("R12 key after reset", cur_key, 0);
        check("R12 offset after reset", cur_off, 0);
    endtask

    task automatic t_signature();
        @(negedge clk); reg_off = 0; reg_size = 8; #1;
        check("R2 full signature", reg_rdata, 64'h4346_4744_4D41_3031);
        reg_off = 4; reg_size = 4; #1;
        check("R2 low word", reg_rdata, 64'h4D41_3031);
        reg_off = 2; reg_size = 2; #1;
        check("R2 middle half", reg_rdata, 64'h4744);
        reg_off = 6; reg_size = 4; #1;
        check("R2 past end", reg_rdata, 64'h0);
    endtask

    task automatic t_reject();
        put_desc(8'h00, C_SEL | 32'h0002_0000, 0, 0);
        @(negedge clk);
        reg_wr = 1; reg_off = 0; reg_size = 2; reg_wdata = 64'h0; #1;
        check("R1 2-byte write rejected", reg_rej, 1);
        @(negedge clk);
        reg_off = 2; reg_size = 4; #1;
        check("R1 4-byte at offset 2 rejected", reg_rej, 1);
        @(negedge clk);
        reg_wr = 0;
        @(negedge clk);
        check("R1 no transfer started", {busy, word_at(8'h00)}, {1'b0, C_SEL | 32'h0002_0000});
    endtask

    task automatic t_read();
        put_desc(8'h00, C_SEL | 32'h0001_0000 | C_RD, 4, 64'h80);
        run64(64'h00);
        check("R4 R6 read copies item bytes",
              {mem[8'h80], mem[8'h81], mem[8'h82], mem[8'h83]}, 32'h10111213);
        check("R10 success write-back", word_at(8'h00), 32'h0);
        check("R6 offset after read", cur_off, 4);
        mem[8'h88] = 8'hFF; mem[8'h89] = 8'hFF; mem[8'h8A] = 8'hFF; mem[8'h8B] = 8'hFF;
        put_desc(8'h00, C_RD, 4, 64'h88);
        run64(64'h00);
        check("R6 R13 zero fill past end",
              {mem[8'h88], mem[8'h89], mem[8'h8A], mem[8'h8B]}, 32'h14150000);
        check("R6 offset stops at item end", cur_off, 6);
    endtask

    task automatic t_skip();
        put_desc(8'h00, C_SEL | 32'h0001_0000 | C_SKIP, 3, 0);
        run64(64'h00);
        check("R8 skip advances offset", cur_off, 3);
        put_desc(8'h00, C_RD, 1, 64'h90);
        run64(64'h00);
        check("R8 R13 read after skip", mem[8'h90], 8'h13);
        put_desc(8'h00, C_SKIP, 10, 0);
        run64(64'h00);
        check("R8 skip clipped to item end", cur_off, 6);
        check("R8 skip completes cleanly", word_at(8'h00), 0);
    endtask

    task automatic t_select_only();
        put_desc(8'h00, C_SEL | 32'h0002_0000, 5, 64'h90);
        run64(64'h00);
        check("R5 select-only key", cur_key, 2);
        check("R5 select-only offset", cur_off, 0);
        check("R5 select-only moves no data", mem[8'h90], 8'h13);
        check("R5 select-only write-back", word_at(8'h00), 0);
    endtask

    task automatic t_priority();
        put_desc(8'h00, C_SEL | C_RD | C_WR | C_SKIP, 2, 64'h98);
        run64(64'h00);
        check("R5 read wins priority", {mem[8'h98], mem[8'h99]}, 16'h5349);
        check("R5 priority no error", word_at(8'h00), 0);
        check("R5 priority offset", cur_off, 2);
    endtask

    task automatic t_write();
        put_desc(8'h00, C_SEL | C_WR, 2, 64'h60);
        run64(64'h00);
        check("R7 read-only item error", word_at(8'h00), 1);
        check("R7 read-only item untouched", {itm[0][0], itm[0][1]}, 16'h5349);
        mem[8'h60] = 8'hA1; mem[8'h61] = 8'hA2;
        put_desc(8'h00, C_SEL | 32'h0001_0000 | C_WR, 2, 64'h60);
        run64(64'h00);
        check("R7 write stores bytes", {itm[1][0], itm[1][1]}, 16'hA1A2);
        check("R7 write success", word_at(8'h00), 0);
        check("R7 write offset", cur_off, 2);
        for (int i = 0; i < 6; i++) mem[8'h60 + 8'(i)] = 8'hB1 + 8'(i);
        put_desc(8'h00, C_WR, 6, 64'h60);
        run64(64'h00);
        check("R7 write past end stored part",
              {itm[1][2], itm[1][3], itm[1][4], itm[1][5]}, 32'hB1B2B3B4);
        check("R7 write past end error", word_at(8'h00), 1);
        check("R7 write past end offset", cur_off, 6);
    endtask

    task automatic t_invalid_read();
        mem[8'hA0] = 8'hEE; mem[8'hA1] = 8'hEE; mem[8'hA2] = 8'hEE;
        put_desc(8'h00, C_SEL | 32'h0009_0000 | C_RD, 3, 64'hA0);
        run64(64'h00);
        check("R6 invalid key zero fill", {mem[8'hA0], mem[8'hA1], mem[8'hA2]}, 24'h0);
        check("R6 invalid key no error", word_at(8'h00), 0);
    endtask

    task automatic t_faults();
        mem[8'hF0] = 8'hAA; mem[8'hF1] = 8'hAA; mem[8'hF2] = 8'hAA; mem[8'hF3] = 8'hAA;
        mem[8'hF4] = 8'h55;
        run64(64'hF0);
        check("R9 R10 fetch fault write-back", word_at(8'hF0), 1);
        check("R10 other descriptor bytes kept", mem[8'hF4], 8'h55);
        put_desc(8'h00, C_SEL | 32'h0001_0000 | C_WR, 2, 64'hE0);
        run64(64'h00);
        check("R9 data fault error", word_at(8'h00), 1);
        check("R9 data fault no advance", cur_off, 0);
    endtask

    task automatic t_trigger_forms();
        put_desc(8'h40, C_SEL | 32'h0001_0000, 0, 0);
        wr_reg(3'd0, 4'd4, 64'h0);
        wr_reg(3'd4, 4'd4, 64'h40);
        wait_idle();
        check("R3 split trigger", {word_at(8'h40), cur_key}, {32'h0, 16'd1});
        put_desc(8'h40, C_SEL | 32'h0000_0000, 0, 0);
        put_desc(8'h20, C_SEL | 32'h0002_0000, 0, 0);
        wr_reg(3'd0, 4'd4, 64'h1);
        run64(64'h40);
        check("R3 64-bit trigger", {word_at(8'h40), cur_key}, {32'h0, 16'd0});
        wr_reg(3'd4, 4'd4, 64'h20);
        wait_idle();
        check("R3 high half cleared at start", {word_at(8'h20), cur_key}, {32'h0, 16'd2});
    endtask

    task automatic t_busy_ignore();
        put_desc(8'h00, C_SEL | C_RD, 4, 64'h80);
        put_desc(8'h20, C_RD, 1, 64'hB0);
        wr_reg(3'd0, 4'd8, 64'h00);
        reg_wr = 1; reg_off = 0; reg_size = 8; reg_wdata = 64'h20;
        sel_wr = 1; sel_key = 16'd2;
        @(negedge clk);
        reg_wr = 0; sel_wr = 0;
        wait_idle();
        check("R11 second trigger ignored", word_at(8'h20), C_RD);
        check("R11 first transfer done", word_at(8'h00), 0);
        check("R11 selector ignored while busy", {cur_key, cur_off}, {16'd0, 32'd4});
        @(negedge clk);
        sel_wr = 1; sel_key = 16'd1;
        @(negedge clk);
        sel_wr = 0;
        check("R13 idle selector write", {cur_key, cur_off}, {16'd1, 32'd0});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_signature();
        t_reject();
        t_read();
        t_skip();
        t_select_only();
        t_priority();
        t_write();
        t_invalid_read();
        t_faults();
        t_trigger_forms();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule